// File: doc/BRIEF.md
# Calendar Clock Update Engine

This block holds a time-of-day and calendar in a small bank of byte registers: seconds, minutes, hours, day of week, day of month, month and year. Each rising one-hertz tick opens an update window. While the window is open a status bit warns software that the time registers are about to change or are changing. Partway through the window the whole calendar advances by one second, with every carry handled. A single-cycle pulse marks the point where the window closes.

Software reads and writes the bank through a byte-wide register port addressed by a 4-bit index. A mode register selects BCD or binary encoding and 12-hour or 24-hour hours. The same register has a hold bit that stops the automatic advance, so that a new time can be loaded without being overtaken by a tick. Writes to the time registers made while the window is open are dropped, so that software never races the advance.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the registers read as follows: seconds 0x00 (address 0), minutes 0x00 (address 2), hours 0x00 (address 4), day of week 0x01 (address 6), day of month 0x01 (address 7), month 0x01 (address 8), year 0x00 (address 9). The mode register (address 11) reads 0x02, which selects BCD and 24-hour mode. The status register (address 10) reads 0x00.
- R2: When a tick arrives while no window is open and the hold bit is clear, bit 7 of address 10 goes high for exactly LEAD_CYC+TAIL_CYC cycles. The time registers advance once, LEAD_CYC cycles after the tick edge.
- R3: `upd_done` is high for exactly one cycle. It is high in the first cycle in which the window bit reads low again.
- R4: While bit 7 of the mode register (the hold bit) is 1, ticks open no window and the time does not advance. Writes to the time registers still take effect.
- R5: A write to any time register (addresses 0, 2, 4, 6, 7, 8, 9) made while the window is open is ignored.
- R6: In 24-hour mode, seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap 23→0 and carry into the day of week (7→1) and into the day of month.
- R7: Bit 2 of the mode register selects the encoding. When it is 0 every time value is BCD (0x09 advances to 0x10). When it is 1 every time value is binary (0x09 advances to 0x0A, and 0x3B wraps to 0x00).
- R8: When bit 1 of the mode register is 0 (12-hour mode), hours run 12, 1, …, 11, and bit 7 of the hours byte means PM. The hour 11 advances to 12 and toggles PM. The hour 12 advances to 1. 11 PM rolls to 12 AM and advances the date.
- R9: The day of month wraps to 1 after the last day of its month and then advances the month. April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4 and 28 otherwise. Every other month has 31 days. Month 12 wraps to 1 and advances the year, and year 99 wraps to 0.
- R10: Address 13 always reads 0x80 (time valid) and address 12 reads 0x00. The alarm bytes at addresses 1, 3 and 5 read back the last value written to them and are never changed by an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| upd_done | output | 1 | One-cycle pulse when the update window closes |

## Verification
The properties assume that `tick_1hz` is a single-cycle pulse and that ticks are spaced further apart than one full window, so that a tick is never expected to stretch or restart an open window. The frozen-seconds property also assumes that software does not toggle the hold bit in the middle of a window. The directed stimulus issues each tick alone and waits for `upd_done`, or for the window bit to fall, before the next one. The only write made during a window targets a time register; that write is the subject of R5, and the hold bit is never touched while a window is open.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

  localparam int unsigned ADR_SEC   = 0;
  localparam int unsigned ADR_SEC_A = 1;
  localparam int unsigned ADR_MIN   = 2;
  localparam int unsigned ADR_MIN_A = 3;
  localparam int unsigned ADR_HR    = 4;
  localparam int unsigned ADR_HR_A  = 5;
  localparam int unsigned ADR_DOW   = 6;
  localparam int unsigned ADR_DOM   = 7;
  localparam int unsigned ADR_MON   = 8;
  localparam int unsigned ADR_YEAR  = 9;
  localparam int unsigned ADR_STAT  = 10;
  localparam int unsigned ADR_MODE  = 11;
  localparam int unsigned ADR_FLAG  = 12;
  localparam int unsigned ADR_VALID = 13;

  typedef enum logic [1:0] {W_IDLE, W_LEAD, W_TAIL} win_state_e;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] dow;
    logic [7:0] dom;
    logic [7:0] mon;
    logic [7:0] year;
  } cal_t;

  // stored byte -> plain number
  function automatic logic [6:0] to_num(input logic [7:0] b, input logic bin);
    if (bin) return b[6:0];
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  // plain number -> stored byte
  function automatic logic [7:0] to_byte(input logic [6:0] v, input logic bin);
    if (bin) return {1'b0, v};
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] days_in(input logic [6:0] month, input logic leap);
    case (month)
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      7'd2:                    return leap ? 7'd29 : 7'd28;
      default:                 return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/calclk_window.sv
module calclk_window
  import calclk_pkg::*;
#(
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned TAIL_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  output logic uip,
  output logic step,
  output logic done
);
  localparam int unsigned MAXC = (LEAD_CYC > TAIL_CYC) ? LEAD_CYC : TAIL_CYC;
  localparam int unsigned CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] LEAD_END = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] TAIL_END = CW'(TAIL_CYC - 1);

  win_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        W_IDLE: if (tick && !hold) begin
          st_q  <= W_LEAD;
          cnt_q <= '0;
        end
        W_LEAD: if (cnt_q == LEAD_END) begin
          st_q  <= W_TAIL;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        W_TAIL: if (cnt_q == TAIL_END) begin
          st_q   <= W_IDLE;
          done_q <= 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign uip  = (st_q != W_IDLE);
  assign step = (st_q == W_LEAD) && (cnt_q == LEAD_END);
  assign done = done_q;
endmodule

// File: rtl/calclk_advance.sv
module calclk_advance
  import calclk_pkg::*;
(
  input  cal_t cur,
  input  logic bin,
  input  logic h24,
  output cal_t nxt
);
  logic [6:0] s, m, h, w, d, mo, y, dim, nh;
  logic       c_s, c_m, c_h, c_d, c_mo, pm;
  logic [7:0] hb;

  always_comb begin
    s  = to_num(cur.sec, bin);
    m  = to_num(cur.min, bin);
    w  = to_num(cur.dow, bin);
    d  = to_num(cur.dom, bin);
    mo = to_num(cur.mon, bin);
    y  = to_num(cur.year, bin);
    dim = days_in(mo, y[1:0] == 2'b00);
    nxt = cur;

    c_s = (s >= 7'd59);
    nxt.sec = to_byte(c_s ? 7'd0 : s + 7'd1, bin);
    c_m = c_s && (m >= 7'd59);
    if (c_s) nxt.min = to_byte(c_m ? 7'd0 : m + 7'd1, bin);

    pm = cur.hour[7];
    if (h24) begin
      h   = to_num(cur.hour, bin);
      c_h = c_m && (h >= 7'd23);
      nh  = c_h ? 7'd0 : h + 7'd1;
      hb  = to_byte(nh, bin);
    end else begin
      h = to_num({1'b0, cur.hour[6:0]}, bin);
      if (h == 7'd11) begin
        nh  = 7'd12;
        c_h = c_m && pm;
        pm  = !pm;
      end else begin
        nh  = (h >= 7'd12) ? 7'd1 : h + 7'd1;
        c_h = 1'b0;
      end
      hb = to_byte(nh, bin);
      hb[7] = pm;
    end
    if (c_m) nxt.hour = hb;

    c_d = c_h && (d >= dim);
    if (c_h) begin
      nxt.dow = to_byte((w >= 7'd7) ? 7'd1 : w + 7'd1, bin);
      nxt.dom = to_byte(c_d ? 7'd1 : d + 7'd1, bin);
    end
    c_mo = c_d && (mo >= 7'd12);
    if (c_d)  nxt.mon  = to_byte(c_mo ? 7'd1 : mo + 7'd1, bin);
    if (c_mo) nxt.year = to_byte((y >= 7'd99) ? 7'd0 : y + 7'd1, bin);
  end
endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
  import calclk_pkg::*;
#(
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned TAIL_CYC = 8,
  parameter int unsigned AW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          upd_done
);
  localparam int unsigned N_ALARM = 3;

  cal_t       t_q, t_nxt;
  logic [7:0] mode_q;
  logic [7:0] alarm_q [N_ALARM];
  logic       uip, step, is_time;

  calclk_window #(.LEAD_CYC(LEAD_CYC), .TAIL_CYC(TAIL_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .hold(mode_q[7]),
    .uip(uip), .step(step), .done(upd_done)
  );

  calclk_advance u_adv (
    .cur(t_q), .bin(mode_q[2]), .h24(mode_q[1]), .nxt(t_nxt)
  );

  always_comb begin
    case (int'(addr))
      ADR_SEC, ADR_MIN, ADR_HR, ADR_DOW, ADR_DOM, ADR_MON, ADR_YEAR: is_time = 1'b1;
      default: is_time = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q    <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
                  dom: 8'h01, mon: 8'h01, year: 8'h00};
      mode_q <= 8'h02;
      for (int i = 0; i < N_ALARM; i++) alarm_q[i] <= 8'h00;
    end else begin
      if (step && !mode_q[7]) t_q <= t_nxt;
      if (wr_en && !(uip && is_time)) begin
        case (int'(addr))
          ADR_SEC:   t_q.sec  <= wr_data;
          ADR_MIN:   t_q.min  <= wr_data;
          ADR_HR:    t_q.hour <= wr_data;
          ADR_DOW:   t_q.dow  <= wr_data;
          ADR_DOM:   t_q.dom  <= wr_data;
          ADR_MON:   t_q.mon  <= wr_data;
          ADR_YEAR:  t_q.year <= wr_data;
          ADR_MODE:  mode_q   <= wr_data;
          ADR_SEC_A: alarm_q[0] <= wr_data;
          ADR_MIN_A: alarm_q[1] <= wr_data;
          ADR_HR_A:  alarm_q[2] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (int'(addr))
      ADR_SEC:   rd_data = t_q.sec;
      ADR_MIN:   rd_data = t_q.min;
      ADR_HR:    rd_data = t_q.hour;
      ADR_DOW:   rd_data = t_q.dow;
      ADR_DOM:   rd_data = t_q.dom;
      ADR_MON:   rd_data = t_q.mon;
      ADR_YEAR:  rd_data = t_q.year;
      ADR_SEC_A: rd_data = alarm_q[0];
      ADR_MIN_A: rd_data = alarm_q[1];
      ADR_HR_A:  rd_data = alarm_q[2];
      ADR_STAT:  rd_data = {uip, 7'b0};
      ADR_MODE:  rd_data = mode_q;
      ADR_VALID: rd_data = 8'h80;
      default:   rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/calclk_checker.sv
module calclk_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       hold,
  input logic       uip,
  input logic       step,
  input logic       done,
  input logic [7:0] sec_q
);
  AST_STEP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> uip); // R2
  AST_TICK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold && !uip) |=> uip); // R2
  AST_DONE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!uip && $past(uip))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_HOLD_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hold && !uip) |=> !uip); // R4
  AST_SEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (uip && !step) |=> $stable(sec_q)); // R5
endmodule

bind cal_clock_core calclk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .hold(mode_q[7]),
  .uip(uip), .step(step), .done(upd_done), .sec_q(t_q.sec)
);

// File: tb/test_cal_clock_core.sv
module test_cal_clock_core;
  localparam int LEAD = 4;
  localparam int TAIL = 8;

  logic clk = 0, rst_n = 0, tick_1hz = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic upd_done;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  cal_clock_core #(.LEAD_CYC(LEAD), .TAIL_CYC(TAIL)) i_cal_clock_core (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .upd_done(upd_done)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = 4'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rdchk(string req, int a, logic [7:0] exp);
    @(negedge clk); addr = 4'(a); #1;
    chk(req, rd_data, exp);
  endtask

  // tick, then count window cycles; returns count and done at close
  task automatic pulse(output int n, output logic d);
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0; addr = 4'd10;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      #1;
      if (!rd_data[7]) break;
      n++;
      @(negedge clk);
    end
    d = upd_done;
  endtask

  task automatic set_hms(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr(4, h); wr(2, m); wr(0, s);
  endtask

  task automatic t_reset();
    rdchk("R1 sec", 0, 8'h00); rdchk("R1 min", 2, 8'h00);
    rdchk("R1 hour", 4, 8'h00); rdchk("R1 dow", 6, 8'h01);
    rdchk("R1 dom", 7, 8'h01); rdchk("R1 mon", 8, 8'h01);
    rdchk("R1 year", 9, 8'h00); rdchk("R1 mode", 11, 8'h02);
    rdchk("R1 status", 10, 8'h00);
  endtask

  task automatic t_basic();
    int n; logic d;
    wr(0, 8'h09);
    pulse(n, d);
    chk("R2 window length", n, LEAD + TAIL);
    chk("R3 done at close", d, 1);
    @(negedge clk); chk("R3 done one cycle", upd_done, 0);
    rdchk("R7 bcd 09->10", 0, 8'h10);
  endtask

  task automatic t_hold_cascade();
    int n; logic d;
    wr(11, 8'h82);
    set_hms(8'h23, 8'h59, 8'h59); wr(6, 8'h07);
    pulse(n, d);
    chk("R4 no window on hold", n, 0);
    chk("R4 no done on hold", d, 0);
    rdchk("R4 write applies, no advance", 0, 8'h59);
    wr(11, 8'h02);
    pulse(n, d);
    rdchk("R6 sec", 0, 8'h00); rdchk("R6 min", 2, 8'h00);
    rdchk("R6 hour", 4, 8'h00); rdchk("R6 dow 7->1", 6, 8'h01);
    rdchk("R6 dom", 7, 8'h02);
  endtask

  task automatic t_binary();
    int n; logic d;
    wr(11, 8'h06);
    wr(0, 8'h09); pulse(n, d);
    rdchk("R7 bin 09->0A", 0, 8'h0A);
    wr(2, 8'h05); wr(0, 8'h3B); pulse(n, d);
    rdchk("R7 bin sec wrap", 0, 8'h00);
    rdchk("R7 bin min carry", 2, 8'h06);
  endtask

  task automatic t_12h();
    int n; logic d;
    wr(11, 8'h00);
    set_hms(8'h11, 8'h59, 8'h59); pulse(n, d);
    rdchk("R8 11AM->12PM", 4, 8'h92);
    set_hms(8'h12, 8'h59, 8'h59); pulse(n, d);
    rdchk("R8 12AM->1AM", 4, 8'h01);
    wr(7, 8'h05);
    set_hms(8'h91, 8'h59, 8'h59); pulse(n, d);
    rdchk("R8 11PM->12AM", 4, 8'h12);
    rdchk("R8 date advance", 7, 8'h06);
  endtask

  task automatic date_case(string req, logic [7:0] y, logic [7:0] mo, logic [7:0] dd,
                           logic [7:0] ey, logic [7:0] emo, logic [7:0] edd);
    int n; logic d;
    wr(9, y); wr(8, mo); wr(7, dd);
    set_hms(8'h23, 8'h59, 8'h59); pulse(n, d);
    rdchk(req, 7, edd); rdchk(req, 8, emo); rdchk(req, 9, ey);
  endtask

  task automatic t_months();
    wr(11, 8'h02);
    date_case("R9 30-day month", 8'h23, 8'h04, 8'h30, 8'h23, 8'h05, 8'h01);
    date_case("R9 31-day month", 8'h23, 8'h01, 8'h31, 8'h23, 8'h02, 8'h01);
    date_case("R9 feb non-leap", 8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01);
    date_case("R9 feb leap 29", 8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29);
    date_case("R9 feb leap end", 8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01);
    date_case("R9 year wrap", 8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01);
  endtask

  task automatic t_write_in_window();
    wr(0, 8'h41);
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    wr(0, 8'h30); // R5: dropped, window open
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (upd_done) break;
    end
    rdchk("R5 write in window ignored", 0, 8'h42);
  endtask

  task automatic t_misc();
    wr(1, 8'hC5); wr(3, 8'h3A); wr(5, 8'h7E);
    rdchk("R10 valid", 13, 8'h80); rdchk("R10 flags", 12, 8'h00);
    rdchk("R10 alarm sec", 1, 8'hC5); rdchk("R10 alarm min", 3, 8'h3A);
    rdchk("R10 alarm hr", 5, 8'h7E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_hold_cascade();
    t_binary();
    t_12h();
    t_months();
    t_write_in_window();
    t_misc();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule